// File: doc/BRIEF.md
# Keyboard Controller Host Command Processor

This block is the host-facing command engine of a PC-style keyboard and auxiliary-device controller. The host writes single bytes to two ports: a command port and a data port. Each write is a one-cycle strobe with the byte on a shared bus. The block decodes command bytes and keeps three registers: the mode byte, the status byte and the output-port byte. It also keeps a pending opcode for commands that need a second byte. Its outputs are reply bytes for the keyboard or auxiliary reply queue, bytes forwarded to either device, the A20 gate level, a scan-code translation enable, a system reset request pulse and an error pulse for unknown commands.

All results are registered and appear on the cycle after the strobe. Reply and forward outputs are one-cycle valid pulses with no ready input. The reply queues and device links are plain byte sinks that must accept every pulse, so the block never stalls and applies no back-pressure. The host must not issue a write while it has no room for the result.

Top module: `kbc_cmd_proc`

## Requirements
- R1: After reset the mode byte is 0x03, the status byte is 0x18 and the output port is 0xCF. In that state a20_gate is 1, xlate_en is 0, no opcode is pending and no pulse output is high.
- R2: A command byte whose top four bits are all 1 is treated as follows. If bit 0 is 0, sys_reset_req pulses for one cycle. If bit 0 is 1, the byte is a no-op. Neither case raises cmd_err.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only record a pending opcode. The next data-port write carries out that opcode, and the pending opcode then returns to none. A data write after that is forwarded to the keyboard again.
- R4: A data-port write with no pending opcode pulses kbd_fwd_valid with the byte on fwd_byte.
- R5: Command 0x20 replies with the mode byte and command 0xD0 replies with the output port. Both replies go to the keyboard queue (reply_sel = 0).
- R6: Command 0xAA sets status bit 2 and replies 0x55. Commands 0xA9 and 0xAB reply 0x00. Command 0xC0 replies 0x80. All of these replies go to the keyboard queue.
- R7: Command 0xA7 sets mode bit 5 and command 0xA8 clears it. Command 0xAD sets mode bit 4 and command 0xAE clears it. No other mode bit changes.
- R8: Command 0xDF sets a20_gate and output-port bit 1. Command 0xDD clears both.
- R9: A data byte written after 0xD1 becomes the whole output port, and a20_gate follows its bit 1. If its bit 0 is 0, sys_reset_req pulses for one cycle.
- R10: A data byte written after 0x60 becomes the mode byte, and xlate_en takes its bit 6.
- R11: A command byte not listed in R2 to R10 raises cmd_err for one cycle. It changes no register and produces no reply or forward.
- R12: A data byte written after 0xD2 is replied to the keyboard queue (reply_sel = 0). After 0xD3 it is replied to the auxiliary queue (reply_sel = 1). After 0xD4 it is forwarded with aux_fwd_valid.
- R13: Every result appears one cycle after its strobe and lasts one cycle. If cmd_wr and data_wr are high together, the command is carried out and the data write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | One-cycle command-port write strobe |
| data_wr | input | 1 | One-cycle data-port write strobe |
| wr_byte | input | 8 | Byte written by the host |
| reply_valid | output | 1 | Reply byte pulse |
| reply_sel | output | 1 | Reply queue select: 0 keyboard, 1 auxiliary |
| reply_byte | output | 8 | Reply byte |
| kbd_fwd_valid | output | 1 | Forward-to-keyboard pulse |
| aux_fwd_valid | output | 1 | Forward-to-auxiliary pulse |
| fwd_byte | output | 8 | Forwarded byte |
| a20_gate | output | 1 | A20 gate level |
| xlate_en | output | 1 | Scan-code translation enable |
| sys_reset_req | output | 1 | One-cycle system reset request |
| cmd_err | output | 1 | One-cycle unsupported-command strobe |
| mode_q | output | 8 | Mode byte |
| status_q | output | 8 | Status byte |
| outport_q | output | 8 | Output-port byte |

## Verification
The bench builds the block with its default parameters. In particular the reset values of the three registers are the 0x03, 0x18 and 0xCF defaults, so the R1 reset check and the bit-by-bit register checks are tested against those values. With these defaults the bench can cover every command, both pulse-group outcomes, all five two-byte commands and the clearing of the pending opcode, including a write that arrives on both ports in the same cycle.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t OP_RD_MODE  = 8'h20;
  localparam byte_t OP_WR_MODE  = 8'h60;
  localparam byte_t OP_AUX_OFF  = 8'hA7;
  localparam byte_t OP_AUX_ON   = 8'hA8;
  localparam byte_t OP_AUX_TEST = 8'hA9;
  localparam byte_t OP_SELFTEST = 8'hAA;
  localparam byte_t OP_KBD_TEST = 8'hAB;
  localparam byte_t OP_KBD_OFF  = 8'hAD;
  localparam byte_t OP_KBD_ON   = 8'hAE;
  localparam byte_t OP_RD_INP   = 8'hC0;
  localparam byte_t OP_RD_OUTP  = 8'hD0;
  localparam byte_t OP_WR_OUTP  = 8'hD1;
  localparam byte_t OP_WR_KBUF  = 8'hD2;
  localparam byte_t OP_WR_ABUF  = 8'hD3;
  localparam byte_t OP_WR_AUX   = 8'hD4;
  localparam byte_t OP_A20_OFF  = 8'hDD;
  localparam byte_t OP_A20_ON   = 8'hDF;
  localparam byte_t OP_NONE     = 8'h00;

  localparam int MODE_KOFF_BIT = 4;
  localparam int MODE_AOFF_BIT = 5;
  localparam int MODE_XLAT_BIT = 6;
  localparam int STAT_ST_BIT   = 2;
  localparam int OUTP_RST_BIT  = 0;
  localparam int OUTP_A20_BIT  = 1;

  typedef enum logic [1:0] {
    SRC_CONST = 2'd0,
    SRC_MODE  = 2'd1,
    SRC_OUTP  = 2'd2
  } rep_src_e;

  typedef struct packed {
    logic     rep_en;
    rep_src_e rep_src;
    byte_t    rep_const;
    logic     pend_en;
    logic     selftest;
    byte_t    mode_set;
    byte_t    mode_clr;
    logic     a20_set;
    logic     a20_clr;
    logic     sysrst;
    logic     err;
  } cmd_act_t;

  typedef struct packed {
    logic mode_wr;
    logic outp_wr;
    logic rep_en;
    logic rep_aux;
    logic fwd_kbd;
    logic fwd_aux;
  } data_act_t;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  byte_t    cmd_byte,
  output cmd_act_t act
);
  localparam int GRP_W = 4;
  byte_t eff;

  always_comb begin
    eff = cmd_byte;
    if (cmd_byte[BYTE_W-1 -: GRP_W] == {GRP_W{1'b1}})
      eff = cmd_byte[0] ? 8'hFF : 8'hFE;
  end

  always_comb begin
    act = '0;
    act.rep_src = SRC_CONST;
    unique case (eff)
      OP_RD_MODE:  begin act.rep_en = 1'b1; act.rep_src = SRC_MODE; end
      OP_RD_OUTP:  begin act.rep_en = 1'b1; act.rep_src = SRC_OUTP; end
      OP_WR_MODE, OP_WR_OUTP, OP_WR_KBUF, OP_WR_ABUF, OP_WR_AUX:
        act.pend_en = 1'b1;
      OP_AUX_OFF:  act.mode_set[MODE_AOFF_BIT] = 1'b1;
      OP_AUX_ON:   act.mode_clr[MODE_AOFF_BIT] = 1'b1;
      OP_KBD_OFF:  act.mode_set[MODE_KOFF_BIT] = 1'b1;
      OP_KBD_ON:   act.mode_clr[MODE_KOFF_BIT] = 1'b1;
      OP_AUX_TEST, OP_KBD_TEST: begin
        act.rep_en = 1'b1; act.rep_const = 8'h00;
      end
      OP_SELFTEST: begin
        act.rep_en = 1'b1; act.rep_const = 8'h55; act.selftest = 1'b1;
      end
      OP_RD_INP:   begin act.rep_en = 1'b1; act.rep_const = 8'h80; end
      OP_A20_ON:   act.a20_set = 1'b1;
      OP_A20_OFF:  act.a20_clr = 1'b1;
      8'hFE:       act.sysrst = 1'b1;
      8'hFF:       ;
      default:     act.err = 1'b1;
    endcase
  end
endmodule

// File: rtl/kbc_data_exec.sv
module kbc_data_exec
  import kbc_pkg::*;
(
  input  byte_t     pend_op,
  output data_act_t act
);
  always_comb begin
    act = '0;
    unique case (pend_op)
      OP_WR_MODE: act.mode_wr = 1'b1;
      OP_WR_OUTP: act.outp_wr = 1'b1;
      OP_WR_KBUF: act.rep_en  = 1'b1;
      OP_WR_ABUF: begin act.rep_en = 1'b1; act.rep_aux = 1'b1; end
      OP_WR_AUX:  act.fwd_aux = 1'b1;
      default:    act.fwd_kbd = 1'b1;
    endcase
  end
endmodule

// File: rtl/kbc_state_regs.sv
module kbc_state_regs
  import kbc_pkg::*;
#(
  parameter byte_t MODE_RST = 8'h03,
  parameter byte_t STAT_RST = 8'h18,
  parameter byte_t OUTP_RST = 8'hCF
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_go,
  input  logic      data_go,
  input  byte_t     wr_byte,
  input  cmd_act_t  cact,
  input  data_act_t dact,
  output byte_t     mode_q,
  output byte_t     status_q,
  output byte_t     outport_q,
  output byte_t     pend_q,
  output logic      xlate_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_RST;
      status_q  <= STAT_RST;
      outport_q <= OUTP_RST;
      pend_q    <= OP_NONE;
      xlate_q   <= MODE_RST[MODE_XLAT_BIT];
    end else if (cmd_go) begin
      mode_q <= (mode_q | cact.mode_set) & ~cact.mode_clr;
      if (cact.selftest) status_q[STAT_ST_BIT] <= 1'b1;
      if (cact.a20_set) outport_q[OUTP_A20_BIT] <= 1'b1;
      else if (cact.a20_clr) outport_q[OUTP_A20_BIT] <= 1'b0;
      if (cact.pend_en) pend_q <= wr_byte;
    end else if (data_go) begin
      if (dact.mode_wr) begin
        mode_q  <= wr_byte;
        xlate_q <= wr_byte[MODE_XLAT_BIT];
      end
      if (dact.outp_wr) outport_q <= wr_byte;
      pend_q <= OP_NONE;
    end
  end
endmodule

// File: rtl/kbc_out_stage.sv
module kbc_out_stage
  import kbc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_go,
  input  logic      data_go,
  input  byte_t     wr_byte,
  input  cmd_act_t  cact,
  input  data_act_t dact,
  input  byte_t     mode_q,
  input  byte_t     outport_q,
  output logic      reply_valid,
  output logic      reply_sel,
  output byte_t     reply_byte,
  output logic      kbd_fwd_valid,
  output logic      aux_fwd_valid,
  output byte_t     fwd_byte,
  output logic      sys_reset_req,
  output logic      cmd_err
);
  byte_t cmd_rep;

  always_comb begin
    unique case (cact.rep_src)
      SRC_MODE: cmd_rep = mode_q;
      SRC_OUTP: cmd_rep = outport_q;
      default:  cmd_rep = cact.rep_const;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reply_valid   <= 1'b0;
      reply_sel     <= 1'b0;
      reply_byte    <= '0;
      kbd_fwd_valid <= 1'b0;
      aux_fwd_valid <= 1'b0;
      fwd_byte      <= '0;
      sys_reset_req <= 1'b0;
      cmd_err       <= 1'b0;
    end else begin
      reply_valid   <= 1'b0;
      kbd_fwd_valid <= 1'b0;
      aux_fwd_valid <= 1'b0;
      sys_reset_req <= 1'b0;
      cmd_err       <= 1'b0;
      if (cmd_go) begin
        if (cact.rep_en) begin
          reply_valid <= 1'b1;
          reply_sel   <= 1'b0;
          reply_byte  <= cmd_rep;
        end
        sys_reset_req <= cact.sysrst;
        cmd_err       <= cact.err;
      end else if (data_go) begin
        if (dact.rep_en) begin
          reply_valid <= 1'b1;
          reply_sel   <= dact.rep_aux;
          reply_byte  <= wr_byte;
        end
        if (dact.fwd_kbd || dact.fwd_aux) fwd_byte <= wr_byte;
        kbd_fwd_valid <= dact.fwd_kbd;
        aux_fwd_valid <= dact.fwd_aux;
        sys_reset_req <= dact.outp_wr && !wr_byte[OUTP_RST_BIT];
      end
    end
  end
endmodule

// File: rtl/kbc_cmd_proc.sv
module kbc_cmd_proc
  import kbc_pkg::*;
#(
  parameter byte_t MODE_RST = 8'h03,
  parameter byte_t STAT_RST = 8'h18,
  parameter byte_t OUTP_RST = 8'hCF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              reply_valid,
  output logic              reply_sel,
  output logic [BYTE_W-1:0] reply_byte,
  output logic              kbd_fwd_valid,
  output logic              aux_fwd_valid,
  output logic [BYTE_W-1:0] fwd_byte,
  output logic              a20_gate,
  output logic              xlate_en,
  output logic              sys_reset_req,
  output logic              cmd_err,
  output logic [BYTE_W-1:0] mode_q,
  output logic [BYTE_W-1:0] status_q,
  output logic [BYTE_W-1:0] outport_q
);
  cmd_act_t  cact;
  data_act_t dact;
  byte_t     pend_q;
  logic      data_go;

  assign data_go = data_wr && !cmd_wr;

  kbc_cmd_decode u_dec (.cmd_byte(wr_byte), .act(cact));
  kbc_data_exec  u_dex (.pend_op(pend_q), .act(dact));

  kbc_state_regs #(
    .MODE_RST(MODE_RST), .STAT_RST(STAT_RST), .OUTP_RST(OUTP_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_wr), .data_go(data_go),
    .wr_byte(wr_byte), .cact(cact), .dact(dact),
    .mode_q(mode_q), .status_q(status_q), .outport_q(outport_q),
    .pend_q(pend_q), .xlate_q(xlate_en)
  );

  kbc_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_wr), .data_go(data_go),
    .wr_byte(wr_byte), .cact(cact), .dact(dact),
    .mode_q(mode_q), .outport_q(outport_q),
    .reply_valid(reply_valid), .reply_sel(reply_sel), .reply_byte(reply_byte),
    .kbd_fwd_valid(kbd_fwd_valid), .aux_fwd_valid(aux_fwd_valid),
    .fwd_byte(fwd_byte), .sys_reset_req(sys_reset_req), .cmd_err(cmd_err)
  );

  assign a20_gate = outport_q[OUTP_A20_BIT];
endmodule

// File: rtl/kbc_cmd_proc_chk.sv
module kbc_cmd_proc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic       data_wr,
  input logic       reply_valid,
  input logic       reply_sel,
  input logic       kbd_fwd_valid,
  input logic       aux_fwd_valid,
  input logic       sys_reset_req,
  input logic       cmd_err,
  input logic [7:0] mode_q,
  input logic [7:0] status_q,
  input logic [7:0] outport_q
);
  p_result_from_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid || kbd_fwd_valid || aux_fwd_valid || sys_reset_req || cmd_err)
      |-> $past(cmd_wr || data_wr));

  p_err_only_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_wr));

  p_err_no_reply_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !reply_valid && !sys_reset_req);

  p_one_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reply_valid, kbd_fwd_valid, aux_fwd_valid}));

  p_aux_reply_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && reply_sel) |-> $past(data_wr && !cmd_wr));

  p_fwd_data_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_fwd_valid |-> $past(data_wr && !cmd_wr));

  p_regs_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_wr && !data_wr) |=> ($stable(mode_q) && $stable(outport_q) && $stable(status_q)));

  p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[2] |=> status_q[2]);
endmodule

bind kbc_cmd_proc kbc_cmd_proc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
  .reply_valid(reply_valid), .reply_sel(reply_sel),
  .kbd_fwd_valid(kbd_fwd_valid), .aux_fwd_valid(aux_fwd_valid),
  .sys_reset_req(sys_reset_req), .cmd_err(cmd_err),
  .mode_q(mode_q), .status_q(status_q), .outport_q(outport_q)
);

// File: tb/kbc_cmd_proc_tb.sv
module kbc_cmd_proc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic       data_wr = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       reply_valid, reply_sel, kbd_fwd_valid, aux_fwd_valid;
  logic [7:0] reply_byte, fwd_byte, mode_q, status_q, outport_q;
  logic       a20_gate, xlate_en, sys_reset_req, cmd_err;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  kbc_cmd_proc u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
    .wr_byte(wr_byte), .reply_valid(reply_valid), .reply_sel(reply_sel),
    .reply_byte(reply_byte), .kbd_fwd_valid(kbd_fwd_valid),
    .aux_fwd_valid(aux_fwd_valid), .fwd_byte(fwd_byte), .a20_gate(a20_gate),
    .xlate_en(xlate_en), .sys_reset_req(sys_reset_req), .cmd_err(cmd_err),
    .mode_q(mode_q), .status_q(status_q), .outport_q(outport_q)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // strobe for one cycle; returns at the next falling edge where results are visible
  task automatic wr(input logic c, input logic d, input logic [7:0] b);
    @(negedge clk);
    cmd_wr = c; data_wr = d; wr_byte = b;
    @(negedge clk);
    cmd_wr = 1'b0; data_wr = 1'b0;
  endtask

  task automatic chk_reply(input string req, input logic sel, input logic [7:0] b);
    chk(req, "reply_valid", reply_valid, 1);
    chk(req, "reply_sel", reply_sel, sel);
    chk(req, "reply_byte", reply_byte, b);
  endtask

  task automatic t_reset;
    chk("R1", "mode", mode_q, 8'h03);
    chk("R1", "status", status_q, 8'h18);
    chk("R1", "outport", outport_q, 8'hCF);
    chk("R1", "a20", a20_gate, 1);
    chk("R1", "xlate", xlate_en, 0);
    chk("R1", "pulses", {reply_valid, kbd_fwd_valid, aux_fwd_valid, sys_reset_req, cmd_err}, 0);
  endtask

  task automatic t_replies;
    wr(1, 0, 8'h20); chk_reply("R5", 0, 8'h03);
    wr(1, 0, 8'hD0); chk_reply("R5", 0, 8'hCF);
    wr(1, 0, 8'hAA); chk_reply("R6", 0, 8'h55);
    chk("R6", "status", status_q, 8'h1C);
    wr(1, 0, 8'hA9); chk_reply("R6", 0, 8'h00);
    wr(1, 0, 8'hAB); chk_reply("R6", 0, 8'h00);
    wr(1, 0, 8'hC0); chk_reply("R6", 0, 8'h80);
    @(negedge clk);
    chk("R13", "reply one cycle", reply_valid, 0);
  endtask

  task automatic t_mode_bits;
    wr(1, 0, 8'hA7); chk("R7", "mode aux off", mode_q, 8'h23);
    wr(1, 0, 8'hA8); chk("R7", "mode aux on", mode_q, 8'h03);
    wr(1, 0, 8'hAD); chk("R7", "mode kbd off", mode_q, 8'h13);
    wr(1, 0, 8'hAE); chk("R7", "mode kbd on", mode_q, 8'h03);
    chk("R7", "no reply", reply_valid, 0);
  endtask

  task automatic t_a20;
    wr(1, 0, 8'hDD);
    chk("R8", "a20 off", a20_gate, 0);
    chk("R8", "outport off", outport_q, 8'hCD);
    wr(1, 0, 8'hDF);
    chk("R8", "a20 on", a20_gate, 1);
    chk("R8", "outport on", outport_q, 8'hCF);
  endtask

  task automatic t_pulse_group;
    wr(1, 0, 8'hF0);
    chk("R2", "F0 reset", sys_reset_req, 1);
    chk("R2", "F0 err", cmd_err, 0);
    @(negedge clk);
    chk("R13", "reset one cycle", sys_reset_req, 0);
    wr(1, 0, 8'hFF);
    chk("R2", "FF reset", sys_reset_req, 0);
    chk("R2", "FF err", cmd_err, 0);
    wr(1, 0, 8'hF7);
    chk("R2", "F7 reset", sys_reset_req, 0);
    chk("R2", "F7 err", cmd_err, 0);
    wr(1, 0, 8'hFA);
    chk("R2", "FA reset", sys_reset_req, 1);
    chk("R2", "regs kept", {mode_q, outport_q}, 16'h03CF);
  endtask

  task automatic t_two_byte;
    wr(1, 0, 8'h60);
    chk("R3", "pending only", {reply_valid, kbd_fwd_valid, mode_q}, 10'h003);
    wr(0, 1, 8'h43);
    chk("R10", "mode", mode_q, 8'h43);
    chk("R10", "xlate", xlate_en, 1);
    chk("R3", "no fwd", kbd_fwd_valid, 0);
    wr(0, 1, 8'h11);
    chk("R3", "cleared fwd", kbd_fwd_valid, 1);
    chk("R3", "cleared byte", fwd_byte, 8'h11);
    chk("R3", "mode kept", mode_q, 8'h43);
    wr(1, 0, 8'h60); wr(0, 1, 8'h03);
    chk("R10", "xlate off", xlate_en, 0);
    wr(1, 0, 8'hD1); wr(0, 1, 8'hCD);
    chk("R9", "outport", outport_q, 8'hCD);
    chk("R9", "a20", a20_gate, 0);
    chk("R9", "no reset", sys_reset_req, 0);
    wr(1, 0, 8'hD1); wr(0, 1, 8'hCE);
    chk("R9", "outport", outport_q, 8'hCE);
    chk("R9", "a20", a20_gate, 1);
    chk("R9", "reset", sys_reset_req, 1);
    wr(1, 0, 8'hD2); wr(0, 1, 8'h5A); chk_reply("R12", 0, 8'h5A);
    wr(1, 0, 8'hD3); wr(0, 1, 8'h77); chk_reply("R12", 1, 8'h77);
    wr(1, 0, 8'hD4); wr(0, 1, 8'h99);
    chk("R12", "aux fwd", aux_fwd_valid, 1);
    chk("R12", "kbd fwd", kbd_fwd_valid, 0);
    chk("R12", "fwd byte", fwd_byte, 8'h99);
  endtask

  task automatic t_forward;
    wr(0, 1, 8'h3C);
    chk("R4", "kbd fwd", kbd_fwd_valid, 1);
    chk("R4", "fwd byte", fwd_byte, 8'h3C);
    chk("R4", "no reply", reply_valid, 0);
  endtask

  task automatic t_unsupported;
    wr(1, 0, 8'h12);
    chk("R11", "err", cmd_err, 1);
    chk("R11", "no reply", reply_valid, 0);
    chk("R11", "regs", {mode_q, status_q, outport_q}, 24'h031CCE);
    wr(0, 1, 8'h44);
    chk("R11", "no pending", kbd_fwd_valid, 1);
  endtask

  task automatic t_both;
    wr(1, 0, 8'h60);
    wr(1, 1, 8'h20);
    chk_reply("R13", 0, 8'h03);
    chk("R13", "data ignored fwd", kbd_fwd_valid, 0);
    wr(0, 1, 8'h07);
    chk("R13", "pending kept", mode_q, 8'h07);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_replies();
        t_mode_bits();
        t_a20();
        t_pulse_group();
        t_two_byte();
        t_forward();
        t_unsupported();
        t_both();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule